// File: doc/BRIEF.md
# Processor reset and mode controller

This block brings a small processor core out of reset and keeps track of its privilege mode. While the external active-low reset input is held low, the controller stays in a reset phase. Once that input is released, it runs a fixed countdown of a parameterised number of cycles. At the end of the countdown it places the core in supervisor mode and raises a one-cycle fetch request for the reset vector address.

Privileged software can start the same countdown with a request strobe. The request is honoured only when the tracked mode is supervisor or emulation, and the controller then returns to the mode that made it. A request from user mode, or one that arrives during a countdown, is dropped. The core changes mode at run time through a mode-change strobe.

During every reset phase the controller drives the initial values of the interrupt pending, mask and latch words, the cycle-counter enable, the protection-table enable, the two cache enables and the rounding selection. It also latches the boot-mode and clock-select strap pins, but only during the external reset.

Top module: `core_reset_ctrl`

## Requirements
- R1: On every clock edge at which `rst_ext_n` is low, the controller enters the reset phase. After such an edge `mode_o` is 2'b11 (reset), `busy_o` is 1 and `vec_fetch_o` is 0.
- R2: From the first edge at which `rst_ext_n` is sampled high, `busy_o` stays high for exactly SEQ_CYCLES cycles. Then `busy_o` falls, `mode_o` becomes 2'b01 (supervisor), and `vec_fetch_o` is high for exactly one cycle, with `vec_addr_o` equal to RESET_VEC.
- R3: A high `sw_rst_req` sampled while idle, with `mode_o` at 2'b01 (supervisor) or 2'b10 (emulation), makes `busy_o` high and `mode_o` 2'b11 after that edge.
- R4: A countdown started by software lasts SEQ_CYCLES cycles. It ends with `mode_o` equal to the mode that made the request, together with the one-cycle vector fetch. A countdown started by the external reset always ends in supervisor mode.
- R5: A `sw_rst_req` sampled while `mode_o` is 2'b00 (user) has no effect: `busy_o` stays low, `mode_o` stays 2'b00 and no vector fetch occurs.
- R6: A `sw_rst_req` sampled while `busy_o` is high neither restarts nor lengthens the running countdown.
- R7: After any countdown, `ipend_o` holds only bit GDIS_BIT set (16'h0010 with defaults), and `imask_o` and `ilat_o` are all zero.
- R8: After any countdown, `cyc_cnt_en_o`, `prot_tbl_en_o`, `icache_en_o` and `dcache_en_o` are 0 and `round_unbiased_o` is 1.
- R9: `boot_mode_o` and `clk_sel_o` hold the values that `boot_pins` and `msel_pins` had on the last edge at which `rst_ext_n` was low. They do not change while `rst_ext_n` is high, including during software-started countdowns.
- R10: While idle, a high `mode_chg_vld` loads `mode_chg_val` into `mode_o` on the next edge. The value 2'b11 is ignored. The strobe is ignored while `busy_o` is high. An accepted `sw_rst_req` in the same cycle takes precedence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_ext_n | input | 1 | External reset, active low, sampled on the clock |
| sw_rst_req | input | 1 | Software reset request strobe |
| mode_chg_vld | input | 1 | Mode change strobe |
| mode_chg_val | input | 2 | Requested mode: 00 user, 01 supervisor, 10 emulation |
| boot_pins | input | BOOT_W | Boot-mode strap pins |
| msel_pins | input | MSEL_W | Clock multiplier select strap pins |
| mode_o | output | 2 | Current mode: 00 user, 01 supervisor, 10 emulation, 11 reset |
| busy_o | output | 1 | High during the reset phase and the countdown |
| vec_fetch_o | output | 1 | One-cycle request to fetch from the reset vector |
| vec_addr_o | output | ADDR_W | Reset vector address |
| ipend_o | output | IRQ_W | Initial interrupt pending word |
| imask_o | output | IRQ_W | Initial interrupt mask word |
| ilat_o | output | IRQ_W | Initial interrupt latch word |
| cyc_cnt_en_o | output | 1 | Cycle counter enable |
| prot_tbl_en_o | output | 1 | Memory protection table enable |
| icache_en_o | output | 1 | Instruction cache enable |
| dcache_en_o | output | 1 | Data cache enable |
| round_unbiased_o | output | 1 | Selects unbiased rounding |
| boot_mode_o | output | BOOT_W | Latched boot mode |
| clk_sel_o | output | MSEL_W | Latched clock select |

## Verification
The bench builds the block with SEQ_CYCLES=5, RESET_VEC=32'h0000_2000, BOOT_W=2 and MSEL_W=5. The short countdown lets one run cover several hardware and software resets. A countdown of 5, which is not a power of two, exercises the derived counter width and terminal count rather than a natural wrap. A non-zero vector shows that the fetch address follows the parameter. The five-bit clock select lets the bench change each strap to a distinct value right before release, and again during software countdowns, so capture timing and holding can both be seen.

// File: rtl/core_rst_pkg.sv
package core_rst_pkg;

  // Mode encoding shared by the controller and its ports.
  localparam logic [1:0] MODE_USER = 2'b00;
  localparam logic [1:0] MODE_SUPV = 2'b01;
  localparam logic [1:0] MODE_EMU  = 2'b10;
  localparam logic [1:0] MODE_RST  = 2'b11;

  // Internal phase of the controller.
  typedef enum logic [1:0] {
    PH_HOLD = 2'b00,
    PH_SEQ  = 2'b01,
    PH_RUN  = 2'b10
  } rst_phase_e;

  // Privileged modes may raise a software reset.
  function automatic logic mode_is_priv(input logic [1:0] m);
    return (m == MODE_SUPV) || (m == MODE_EMU);
  endfunction

  // Modes that the core may select at run time.
  function automatic logic mode_is_settable(input logic [1:0] m);
    return m != MODE_RST;
  endfunction

  // Width of a down-counter that must reach n-1.
  function automatic int seq_cnt_width(input int n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/rst_seq_counter.sv
module rst_seq_counter
  import core_rst_pkg::*;
#(
  parameter int SEQ_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_ext_n,
  input  logic start_i,
  output logic running_o,
  output logic done_o
);

  localparam int CW = seq_cnt_width(SEQ_CYCLES);
  localparam logic [CW-1:0] LAST = CW'(SEQ_CYCLES - 1);

  logic          run_q;
  logic [CW-1:0] cnt_q;

  // Terminal count of the running countdown.
  assign done_o    = run_q && (cnt_q == '0);
  assign running_o = run_q;

  always_ff @(posedge clk) begin
    if (!rst_ext_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (!run_q) begin
      if (start_i) begin
        run_q <= 1'b1;
        cnt_q <= LAST;
      end
    end else if (done_o) begin
      run_q <= 1'b0;
    end else begin
      cnt_q <= cnt_q - CW'(1);
    end
  end

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_ext_n) run_q |-> (cnt_q <= LAST)); // R2
  AST_START_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_ext_n) (run_q && start_i && cnt_q != '0) |=> (run_q && cnt_q == $past(cnt_q) - CW'(1))); // R6

endmodule

// File: rtl/rst_mode_tracker.sv
module rst_mode_tracker
  import core_rst_pkg::*;
(
  input  logic       clk,
  input  logic       rst_ext_n,
  input  logic       sw_rst_req,
  input  logic       mode_chg_vld,
  input  logic [1:0] mode_chg_val,
  input  logic       seq_done_i,
  output logic       seq_start_o,
  output logic [1:0] mode_o,
  output logic       busy_o,
  output logic       vec_fetch_o
);

  rst_phase_e phase_q;
  logic [1:0] mode_q;
  logic [1:0] ret_q;
  logic       fetch_q;
  logic       was_rst_q;

  // Named events for the countdown and the assertions.
  logic hw_start;
  logic sw_accept;
  logic chg_ok;

  assign hw_start    = (phase_q == PH_HOLD) && rst_ext_n;
  assign sw_accept   = (phase_q == PH_RUN) && sw_rst_req && mode_is_priv(mode_q);
  assign chg_ok      = (phase_q == PH_RUN) && mode_chg_vld && mode_is_settable(mode_chg_val) && !sw_accept;
  assign seq_start_o = hw_start || sw_accept;

  assign busy_o      = (phase_q != PH_RUN);
  assign mode_o      = busy_o ? MODE_RST : mode_q;
  assign vec_fetch_o = fetch_q;

  always_ff @(posedge clk) begin
    was_rst_q <= !rst_ext_n;
    if (!rst_ext_n) begin
      phase_q <= PH_HOLD;
      mode_q  <= MODE_SUPV;
      ret_q   <= MODE_SUPV;
      fetch_q <= 1'b0;
    end else begin
      fetch_q <= 1'b0;
      case (phase_q)
        PH_HOLD: begin
          phase_q <= PH_SEQ;
          ret_q   <= MODE_SUPV;
        end
        PH_SEQ: begin
          if (seq_done_i) begin
            phase_q <= PH_RUN;
            mode_q  <= ret_q;
            fetch_q <= 1'b1;
          end
        end
        PH_RUN: begin
          if (sw_accept) begin
            phase_q <= PH_SEQ;
            ret_q   <= mode_q;
          end else if (chg_ok) begin
            mode_q <= mode_chg_val;
          end
        end
        default: phase_q <= PH_HOLD;
      endcase
    end
  end

  always_comb begin
    if (was_rst_q === 1'b1) begin
      AST_HOLD_IN_RESET: assert (busy_o && mode_o == MODE_RST && !vec_fetch_o); // R1
    end
  end

  AST_SEQ_TO_FETCH: assert property (@(posedge clk) disable iff (!rst_ext_n) seq_done_i |=> (vec_fetch_o && !busy_o)); // R2
  AST_FETCH_SINGLE: assert property (@(posedge clk) disable iff (!rst_ext_n) vec_fetch_o |=> !vec_fetch_o); // R2
  AST_PRIV_REQ_TAKEN: assert property (@(posedge clk) disable iff (!rst_ext_n) (!busy_o && sw_rst_req && (mode_o == MODE_SUPV || mode_o == MODE_EMU)) |=> (busy_o && mode_o == MODE_RST)); // R3
  AST_END_PRIV: assert property (@(posedge clk) disable iff (!rst_ext_n) $fell(busy_o) |-> ((mode_o == MODE_SUPV || mode_o == MODE_EMU) && vec_fetch_o)); // R4
  AST_USER_REQ_DROPPED: assert property (@(posedge clk) disable iff (!rst_ext_n) (!busy_o && sw_rst_req && mode_o == MODE_USER && !mode_chg_vld) |=> (!busy_o && mode_o == MODE_USER)); // R5
  AST_RESERVED_CHG_IGNORED: assert property (@(posedge clk) disable iff (!rst_ext_n) (!busy_o && mode_chg_vld && mode_chg_val == MODE_RST && !sw_rst_req) |=> $stable(mode_o)); // R10

endmodule

// File: rtl/rst_strap_latch.sv
module rst_strap_latch #(
  parameter int BOOT_W = 2,
  parameter int MSEL_W = 5
) (
  input  logic              clk,
  input  logic              rst_ext_n,
  input  logic [BOOT_W-1:0] boot_pins,
  input  logic [MSEL_W-1:0] msel_pins,
  output logic [BOOT_W-1:0] boot_mode_o,
  output logic [MSEL_W-1:0] clk_sel_o
);

  // Sampled on every edge of the external reset: the last one wins.
  always_ff @(posedge clk) begin
    if (!rst_ext_n) begin
      boot_mode_o <= boot_pins;
      clk_sel_o   <= msel_pins;
    end
  end

  AST_STRAP_HELD: assert property (@(posedge clk) disable iff (!rst_ext_n) rst_ext_n |=> ($stable(boot_mode_o) && $stable(clk_sel_o))); // R9

endmodule

// File: rtl/rst_state_init.sv
module rst_state_init #(
  parameter int IRQ_W    = 16,
  parameter int GDIS_BIT = 4
) (
  input  logic             clk,
  input  logic             rst_ext_n,
  input  logic             load_i,
  output logic [IRQ_W-1:0] ipend_o,
  output logic [IRQ_W-1:0] imask_o,
  output logic [IRQ_W-1:0] ilat_o,
  output logic             cyc_cnt_en_o,
  output logic             prot_tbl_en_o,
  output logic             icache_en_o,
  output logic             dcache_en_o,
  output logic             round_unbiased_o
);

  // Pending word with only the global-disable bit set.
  function automatic logic [IRQ_W-1:0] pend_init();
    logic [IRQ_W-1:0] v;
    v = '0;
    v[GDIS_BIT] = 1'b1;
    return v;
  endfunction

  localparam logic [IRQ_W-1:0] PEND_INIT = pend_init();

  always_ff @(posedge clk) begin
    if (load_i) begin
      ipend_o          <= PEND_INIT;
      imask_o          <= '0;
      ilat_o           <= '0;
      cyc_cnt_en_o     <= 1'b0;
      prot_tbl_en_o    <= 1'b0;
      icache_en_o      <= 1'b0;
      dcache_en_o      <= 1'b0;
      round_unbiased_o <= 1'b1;
    end
  end

  AST_IRQ_ON_EXIT: assert property (@(posedge clk) disable iff (!rst_ext_n) $fell(load_i) |-> (ipend_o == PEND_INIT && imask_o == '0 && ilat_o == '0)); // R7
  AST_ENABLES_ON_EXIT: assert property (@(posedge clk) disable iff (!rst_ext_n) $fell(load_i) |-> (!cyc_cnt_en_o && !prot_tbl_en_o && !icache_en_o && !dcache_en_o && round_unbiased_o)); // R8

endmodule

// File: rtl/core_reset_ctrl.sv
module core_reset_ctrl
  import core_rst_pkg::*;
#(
  parameter int                SEQ_CYCLES = 8,
  parameter int                ADDR_W     = 32,
  parameter logic [ADDR_W-1:0] RESET_VEC  = 32'h0000_1000,
  parameter int                IRQ_W      = 16,
  parameter int                GDIS_BIT   = 4,
  parameter int                BOOT_W     = 2,
  parameter int                MSEL_W     = 5
) (
  input  logic              clk,
  input  logic              rst_ext_n,
  input  logic              sw_rst_req,
  input  logic              mode_chg_vld,
  input  logic [1:0]        mode_chg_val,
  input  logic [BOOT_W-1:0] boot_pins,
  input  logic [MSEL_W-1:0] msel_pins,
  output logic [1:0]        mode_o,
  output logic              busy_o,
  output logic              vec_fetch_o,
  output logic [ADDR_W-1:0] vec_addr_o,
  output logic [IRQ_W-1:0]  ipend_o,
  output logic [IRQ_W-1:0]  imask_o,
  output logic [IRQ_W-1:0]  ilat_o,
  output logic              cyc_cnt_en_o,
  output logic              prot_tbl_en_o,
  output logic              icache_en_o,
  output logic              dcache_en_o,
  output logic              round_unbiased_o,
  output logic [BOOT_W-1:0] boot_mode_o,
  output logic [MSEL_W-1:0] clk_sel_o
);

  logic seq_start;
  logic seq_done;
  logic seq_running;

  rst_seq_counter #(.SEQ_CYCLES(SEQ_CYCLES)) u_cnt (
    .clk       (clk),
    .rst_ext_n (rst_ext_n),
    .start_i   (seq_start),
    .running_o (seq_running),
    .done_o    (seq_done)
  );

  rst_mode_tracker u_mode (
    .clk          (clk),
    .rst_ext_n    (rst_ext_n),
    .sw_rst_req   (sw_rst_req),
    .mode_chg_vld (mode_chg_vld),
    .mode_chg_val (mode_chg_val),
    .seq_done_i   (seq_done),
    .seq_start_o  (seq_start),
    .mode_o       (mode_o),
    .busy_o       (busy_o),
    .vec_fetch_o  (vec_fetch_o)
  );

  rst_strap_latch #(.BOOT_W(BOOT_W), .MSEL_W(MSEL_W)) u_strap (
    .clk         (clk),
    .rst_ext_n   (rst_ext_n),
    .boot_pins   (boot_pins),
    .msel_pins   (msel_pins),
    .boot_mode_o (boot_mode_o),
    .clk_sel_o   (clk_sel_o)
  );

  rst_state_init #(.IRQ_W(IRQ_W), .GDIS_BIT(GDIS_BIT)) u_init (
    .clk              (clk),
    .rst_ext_n        (rst_ext_n),
    .load_i           (busy_o),
    .ipend_o          (ipend_o),
    .imask_o          (imask_o),
    .ilat_o           (ilat_o),
    .cyc_cnt_en_o     (cyc_cnt_en_o),
    .prot_tbl_en_o    (prot_tbl_en_o),
    .icache_en_o      (icache_en_o),
    .dcache_en_o      (dcache_en_o),
    .round_unbiased_o (round_unbiased_o)
  );

  assign vec_addr_o = RESET_VEC;

  // The counter runs only inside a busy phase.
  AST_COUNT_WITHIN_BUSY: assert property (@(posedge clk) disable iff (!rst_ext_n) seq_running |-> busy_o); // R2

endmodule

// File: tb/core_reset_ctrl_tb_top.sv
module core_reset_ctrl_tb_top;

  localparam int          SEQ = 5;
  localparam logic [31:0] VEC = 32'h0000_2000;

  logic        clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_ext_n, sw_rst_req, mode_chg_vld;
  logic [1:0]  mode_chg_val;
  logic [1:0]  boot_pins;
  logic [4:0]  msel_pins;
  logic [1:0]  mode_o;
  logic        busy_o, vec_fetch_o;
  logic [31:0] vec_addr_o;
  logic [15:0] ipend_o, imask_o, ilat_o;
  logic        cyc_cnt_en_o, prot_tbl_en_o, icache_en_o, dcache_en_o, round_unbiased_o;
  logic [1:0]  boot_mode_o;
  logic [4:0]  clk_sel_o;

  core_reset_ctrl #(
    .SEQ_CYCLES(SEQ), .ADDR_W(32), .RESET_VEC(VEC),
    .IRQ_W(16), .GDIS_BIT(4), .BOOT_W(2), .MSEL_W(5)
  ) dut_i (
    .clk(clk), .rst_ext_n(rst_ext_n), .sw_rst_req(sw_rst_req),
    .mode_chg_vld(mode_chg_vld), .mode_chg_val(mode_chg_val),
    .boot_pins(boot_pins), .msel_pins(msel_pins),
    .mode_o(mode_o), .busy_o(busy_o), .vec_fetch_o(vec_fetch_o), .vec_addr_o(vec_addr_o),
    .ipend_o(ipend_o), .imask_o(imask_o), .ilat_o(ilat_o),
    .cyc_cnt_en_o(cyc_cnt_en_o), .prot_tbl_en_o(prot_tbl_en_o),
    .icache_en_o(icache_en_o), .dcache_en_o(dcache_en_o),
    .round_unbiased_o(round_unbiased_o),
    .boot_mode_o(boot_mode_o), .clk_sel_o(clk_sel_o)
  );

  int total = 0;
  int bad   = 0;
  bit finished = 1'b0;

  typedef struct {
    logic [1:0] mode;
    int         len;
  } exp_t;
  exp_t exp_q[$];
  int   busy_run = 0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Driver side: announce the expected end of a countdown.
  task automatic expect_seq(input logic [1:0] m);
    exp_t e;
    e.mode = m;
    e.len  = SEQ;
    exp_q.push_back(e);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (busy_o === 1'b0) break;
    end
  endtask

  task automatic chk_init_values(input string tag);
    chk({"R7 ipend ", tag}, ipend_o, 16'h0010);
    chk({"R7 imask ", tag}, imask_o, 16'h0000);
    chk({"R7 ilat ", tag}, ilat_o, 16'h0000);
    chk({"R8 enables ", tag}, {cyc_cnt_en_o, prot_tbl_en_o, icache_en_o, dcache_en_o}, 4'b0000);
    chk({"R8 rounding ", tag}, round_unbiased_o, 1'b1);
  endtask

  // Monitor: length of each countdown and the result at the fetch.
  always @(negedge clk) begin : monitor
    exp_t e;
    if (rst_ext_n === 1'b0) busy_run = 0;
    else if (busy_o === 1'b1) busy_run++;
    if (vec_fetch_o === 1'b1) begin
      if (exp_q.size() == 0) begin
        chk("R5 R6 unexpected vector fetch", 1, 0);
      end else begin
        e = exp_q.pop_front();
        chk("R2 R4 mode at fetch", mode_o, e.mode);
        chk("R2 R6 countdown length", busy_run, e.len);
        chk("R2 vector address", vec_addr_o, VEC);
        chk("R2 busy low at fetch", busy_o, 1'b0);
      end
      busy_run = 0;
    end
  end

  task automatic finish_run();
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin : watchdog
    #(8 * 200000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      finish_run();
    end
  end

  initial begin : stim
    rst_ext_n = 1'b0; sw_rst_req = 1'b0; mode_chg_vld = 1'b0; mode_chg_val = 2'b00;
    boot_pins = 2'b10; msel_pins = 5'h0A;
    repeat (3) @(negedge clk);
    // R1: reset state while the input is held
    chk("R1 mode in reset", mode_o, 2'b11);
    chk("R1 busy in reset", busy_o, 1'b1);
    chk("R1 no fetch in reset", vec_fetch_o, 1'b0);
    chk_init_values("during hold");
    #1 boot_pins = 2'b01; msel_pins = 5'h13;
    @(negedge clk); #1;
    expect_seq(2'b01);
    rst_ext_n = 1'b1; boot_pins = 2'b11; msel_pins = 5'h1F;
    wait_idle();
    chk("R2 supervisor after release", mode_o, 2'b01);
    chk("R9 boot strap at last reset edge", boot_mode_o, 2'b01);
    chk("R9 clock select at last reset edge", clk_sel_o, 5'h13);
    chk_init_values("after hw countdown");

    // R10: run-time mode changes
    #1 mode_chg_vld = 1'b1; mode_chg_val = 2'b00;
    @(negedge clk);
    chk("R10 change to user", mode_o, 2'b00);
    #1 mode_chg_val = 2'b11;
    @(negedge clk);
    chk("R10 reserved value ignored", mode_o, 2'b00);
    #1 mode_chg_vld = 1'b0;

    // R5: request from user mode dropped
    sw_rst_req = 1'b1;
    @(negedge clk);
    chk("R5 busy after user request", busy_o, 1'b0);
    chk("R5 mode after user request", mode_o, 2'b00);
    #1 sw_rst_req = 1'b0;
    repeat (3) @(negedge clk);
    chk("R5 still idle", busy_o, 1'b0);

    // R3/R4 from emulation, with R6 and R10 noise during the countdown
    #1 mode_chg_vld = 1'b1; mode_chg_val = 2'b10;
    @(negedge clk);
    chk("R10 change to emulation", mode_o, 2'b10);
    #1 mode_chg_vld = 1'b0; sw_rst_req = 1'b1;
    expect_seq(2'b10);
    @(negedge clk);
    chk("R3 busy after privileged request", busy_o, 1'b1);
    chk("R3 reset mode after request", mode_o, 2'b11);
    #1 sw_rst_req = 1'b0; boot_pins = 2'b00; msel_pins = 5'h00;
    @(negedge clk);
    #1 sw_rst_req = 1'b1; mode_chg_vld = 1'b1; mode_chg_val = 2'b00;
    @(negedge clk);
    #1 sw_rst_req = 1'b0; mode_chg_vld = 1'b0;
    wait_idle();
    chk("R4 return to emulation", mode_o, 2'b10);
    chk("R9 boot strap not resampled", boot_mode_o, 2'b01);
    chk("R9 clock select not resampled", clk_sel_o, 5'h13);
    chk_init_values("after sw countdown");

    // R4 from supervisor
    #1 mode_chg_vld = 1'b1; mode_chg_val = 2'b01;
    @(negedge clk);
    #1 mode_chg_vld = 1'b0; sw_rst_req = 1'b1;
    expect_seq(2'b01);
    @(negedge clk);
    #1 sw_rst_req = 1'b0;
    wait_idle();
    chk("R4 return to supervisor", mode_o, 2'b01);

    // R10: accepted request takes precedence over a mode change
    #1 sw_rst_req = 1'b1; mode_chg_vld = 1'b1; mode_chg_val = 2'b00;
    expect_seq(2'b01);
    @(negedge clk);
    chk("R10 request wins over change", mode_o, 2'b11);
    #1 sw_rst_req = 1'b0; mode_chg_vld = 1'b0;
    wait_idle();
    chk("R10 mode after request won", mode_o, 2'b01);

    // R4: hardware reset from emulation ends in supervisor
    #1 mode_chg_vld = 1'b1; mode_chg_val = 2'b10;
    @(negedge clk);
    #1 mode_chg_vld = 1'b0; rst_ext_n = 1'b0;
    @(negedge clk);
    chk("R1 reset entered from emulation", mode_o, 2'b11);
    #1 boot_pins = 2'b11; msel_pins = 5'h05;
    @(negedge clk); #1;
    expect_seq(2'b01);
    rst_ext_n = 1'b1; boot_pins = 2'b10; msel_pins = 5'h1C;
    wait_idle();
    chk("R4 hw reset ends in supervisor", mode_o, 2'b01);
    chk("R9 boot strap recaptured", boot_mode_o, 2'b11);
    chk("R9 clock select recaptured", clk_sel_o, 5'h05);

    repeat (4) @(negedge clk);
    chk("R2 all expected fetches seen", exp_q.size(), 0);
    finish_run();
  end

endmodule